// File: doc/BRIEF.md
# GPIO Bank Interrupt Cause and Summary Unit

This block holds the interrupt logic of a 32-line general-purpose I/O bank. Its input is the vector of line values after the bank's per-line polarity inversion has been applied upstream. The inversion is the only way to pick the sense of a line: with inversion off, a line reports rising edges and active-high levels. With inversion on, it reports falling edges and active-low levels. The vector passes through a two-stage synchronizer. A 0-to-1 change of a synchronized bit latches that line's edge cause. The synchronized bit itself serves as the line's level cause, with no latching.

Software reaches the unit over a simple 32-bit register port. Reads are combinational. Writes take effect at the clock edge. There are three registers: a latched edge-cause register, an edge-enable mask and a level-enable mask. The synchronized input can also be read. A line requests service when its level cause is enabled and set, or when its latched edge cause is enabled and set. Requests are ORed in groups of eight lines. Each group drives one registered summary line to the system interrupt controller.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the edge-cause, edge-mask and level-mask registers read zero, and all four summary outputs are low.
- R2: When a synchronized input bit changes from 0 to 1, the matching edge-cause bit is set and stays set. The input passes through two synchronizer flops, so the bit is set at the third rising clock edge after the input changes.
- R3: A 1-to-0 change of an input bit does not set its edge-cause bit. Falling-edge sensing comes only from the upstream polarity inversion.
- R4: The level cause of a line equals its synchronized input bit and is not latched. When that input returns to 0, the line's level request drops.
- R5: The request of line i is (synced_in[i] AND level_mask[i]) OR (edge_cause[i] AND edge_mask[i]). A latched cause whose edge-mask bit is 0 raises no request.
- R6: Writing to the edge-cause register (byte offset 0x14) clears each bit written as 0 and leaves unchanged each bit written as 1.
- R7: If a new edge and a clearing write reach the same edge-cause bit in the same cycle, the bit ends up set.
- R8: Summary output g (bit g of `irq_summary`) is the OR of the requests of lines 8g to 8g+7.
- R9: Summary outputs are registered, one cycle after the request. Each stays high for as long as any request in its group remains set.
- R10: Register offsets are as follows. At 0x10 is the synchronized input (read-only). At 0x14 is the edge cause. At 0x18 is the edge mask and at 0x1C the level mask, both read/write. Any other offset reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 32 | Polarity-adjusted line values, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_summary | output | 4 | Registered per-group interrupt requests |

## Verification
The bench sweeps every one of the 32 lines. For each line it checks that an edge sets exactly that cause bit and raises only that line's group output. A design with the grouping or bit slicing wrong would light the wrong summary line or a neighbouring cause bit. The bench lines up a clearing write with the exact cycle in which an edge is detected. A design that gives the write priority would lose that event.

The bench also checks that falling inputs latch nothing and that level requests drop as soon as the input goes low. A design that latches levels or detects both edges would leave a summary line stuck high. It also checks that writing 1 preserves cause bits and that unmapped offsets are inert. A design that got the write sense reversed, or decoded the address loosely, would wipe or corrupt the masks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned LINES      = 32;
  localparam int unsigned GROUP_SIZE = 8;
  localparam int unsigned ADDR_W     = 8;
  localparam logic [ADDR_W-1:0] OFS_SYNC  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EMASK = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LMASK = 8'h1C;
endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] sync_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      rise_i,
  input  logic [W-1:0]      level_i,
  output logic [W-1:0]      cause_o,
  output logic [W-1:0]      emask_o,
  output logic [W-1:0]      lmask_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] cause_q, emask_q, lmask_q;
  logic [W-1:0] keep_mask;

  always_comb begin
    keep_mask = '1;
    if (wr_i && addr_i == OFS_CAUSE) keep_mask = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      cause_q <= (cause_q & keep_mask) | rise_i;
      if (wr_i && addr_i == OFS_EMASK) emask_q <= wdata_i;
      if (wr_i && addr_i == OFS_LMASK) lmask_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_SYNC:  rdata_o = level_i;
      OFS_CAUSE: rdata_o = cause_q;
      OFS_EMASK: rdata_o = emask_q;
      OFS_LMASK: rdata_o = lmask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cause_o = cause_q;
  assign emask_o = emask_q;
  assign lmask_o = lmask_q;
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int unsigned W     = 32,
  parameter int unsigned GROUP = 8,
  localparam int unsigned NGRP = W / GROUP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    req_i,
  output logic [NGRP-1:0] irq_o
);
  logic [NGRP-1:0] any_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign any_d[g] = |req_i[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= any_d;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NGRP = LINES / GROUP_SIZE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic [NGRP-1:0]   irq_summary
);
  logic [LINES-1:0] level_w, rise_w, cause_w, emask_w, lmask_w, req_w;

  gpio_in_stage #(.W(LINES), .STAGES(SYNC_STAGES)) in_i (
    .clk(clk), .rst_n(rst_n), .raw_i(line_in),
    .level_o(level_w), .rise_o(rise_w)
  );

  gpio_irq_regs #(.W(LINES)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rise_i(rise_w), .level_i(level_w),
    .cause_o(cause_w), .emask_o(emask_w), .lmask_o(lmask_w),
    .rdata_o(reg_rdata)
  );

  assign req_w = (level_w & lmask_w) | (cause_w & emask_w);

  gpio_irq_summary #(.W(LINES), .GROUP(GROUP_SIZE)) sum_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_w), .irq_o(irq_summary)
  );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
  import gpio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [LINES-1:0]  reg_wdata,
  input logic [LINES-1:0]  rise_w,
  input logic [LINES-1:0]  cause_w,
  input logic [LINES-1:0]  emask_w,
  input logic [LINES-1:0]  lmask_w,
  input logic [LINES-1:0]  level_w,
  input logic [LINES-1:0]  req_w,
  input logic [3:0]        irq_summary
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_summary == '0 && cause_w == '0 && emask_w == '0 && lmask_w == '0)); // R1

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((cause_w & $past(rise_w)) == $past(rise_w))); // R2

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CAUSE && (rise_w & ~reg_wdata) != '0)
      |=> ((cause_w & $past(rise_w & ~reg_wdata)) == $past(rise_w & ~reg_wdata))); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CAUSE && reg_wdata == '0 && rise_w == '0) |=> (cause_w == '0)); // R6

  AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_w & lmask_w) == '0 && (cause_w & emask_w) == '0) |-> (req_w == '0)); // R5

  AST_SUMMARY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w != '0) |=> (irq_summary != '0)); // R9

  AST_SUMMARY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w == '0) |=> (irq_summary == '0)); // R9
endmodule

bind gpio_irq_unit gpio_irq_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rise_w(rise_w), .cause_w(cause_w),
  .emask_w(emask_w), .lmask_w(lmask_w), .level_w(level_w),
  .req_w(req_w), .irq_summary(irq_summary)
);

// File: tb/gpio_irq_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_in = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_summary;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_summary(irq_summary)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd(8'h14, v); chk("R1 cause", v, 0);
    rd(8'h18, v); chk("R1 emask", v, 0);
    rd(8'h1C, v); chk("R1 lmask", v, 0);
    chk("R1 summary", {28'd0, irq_summary}, 0);

    // R2 R8 R9 R6: sweep every line
    for (int i = 0; i < 32; i++) begin
      wr(8'h18, 32'd1 << i);
      @(negedge clk); line_in = 32'd1 << i;
      idle(5);
      rd(8'h14, v); chk("R2 edge latch", v, 32'd1 << i);
      chk("R8 group", {28'd0, irq_summary}, 32'd1 << (i / 8));
      @(negedge clk); line_in = '0;
      idle(5);
      chk("R9 held", {28'd0, irq_summary}, 32'd1 << (i / 8));
      wr(8'h14, 32'd0);
      idle(2);
      rd(8'h14, v); chk("R6 clear", v, 0);
      chk("R9 drop", {28'd0, irq_summary}, 0);
    end

    // R3: falling input latches nothing
    wr(8'h18, '1);
    @(negedge clk); line_in = 32'h0000_0F00;
    idle(5);
    wr(8'h14, 32'd0);
    idle(1);
    @(negedge clk); line_in = '0;
    idle(5);
    rd(8'h14, v); chk("R3 no falling", v, 0);
    chk("R3 summary", {28'd0, irq_summary}, 0);

    // R5: latched cause with edge mask off raises nothing
    wr(8'h18, 32'd0);
    @(negedge clk); line_in = 32'h0001_0000;
    idle(5);
    rd(8'h14, v); chk("R5 cause set", v, 32'h0001_0000);
    chk("R5 masked", {28'd0, irq_summary}, 0);
    @(negedge clk); line_in = '0;
    wr(8'h14, 32'd0);

    // R4: level requests per group, not latched
    for (int g = 0; g < 4; g++) begin
      wr(8'h1C, 32'hFF << (8 * g));
      @(negedge clk); line_in = 32'd1 << (8 * g + 3);
      idle(4);
      chk("R4 level on", {28'd0, irq_summary}, 32'd1 << g);
      rd(8'h10, v); chk("R10 sync read", v, 32'd1 << (8 * g + 3));
      @(negedge clk); line_in = '0;
      idle(4);
      chk("R4 level off", {28'd0, irq_summary}, 0);
    end
    wr(8'h1C, 32'd0);
    wr(8'h14, 32'd0);

    // R6: write-one keeps
    @(negedge clk); line_in = 32'h8000_0002;
    idle(5);
    wr(8'h14, 32'h8000_0000);
    idle(1);
    rd(8'h14, v); chk("R6 keep ones", v, 32'h8000_0000);
    @(negedge clk); line_in = '0;
    wr(8'h14, 32'd0);
    idle(3);

    // R7: clearing write lands in the detection cycle
    @(negedge clk); line_in = 32'h0000_0020;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'd0;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(8'h14, v); chk("R7 edge wins", v, 32'h0000_0020);
    @(negedge clk); line_in = '0;
    wr(8'h14, 32'd0);

    // R10: mask read-back, unmapped offsets
    wr(8'h18, 32'hA5A5_0F0F);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h18, v); chk("R10 emask rb", v, 32'hA5A5_0F0F);
    rd(8'h1C, v); chk("R10 lmask rb", v, 32'h1234_5678);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h18, v); chk("R10 emask kept", v, 32'hA5A5_0F0F);
    rd(8'h1C, v); chk("R10 lmask kept", v, 32'h1234_5678);
    rd(8'h14, v); chk("R10 cause kept", v, 0);
    rd(8'h04, v); chk("R10 unmapped read", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule